// File: doc/BRIEF.md
# DAC Test Waveform Generator

This block produces the digital codes that feed an external resistor or capacitor ladder DAC while it is being characterized on the bench. A two-bit selector chooses one of four patterns: a parked output at zero, a full-range rising sawtooth for transfer-curve capture, a short switching sequence that exercises the slowest settling transitions, and a sine for spectral testing. A width selector places the eight-bit level on either the low byte (narrow drive) or the high byte (wide drive) of a sixteen-bit code bus.

Every level is held for a parameterized number of clock cycles. This gives the analog output time to settle and lets an oscilloscope average several samples of each level. A one-cycle sync pulse marks the first cycle of every waveform period so the capture can be triggered. Selector changes are only taken up at a period boundary. A running period therefore always finishes in the shape it started with. The sine needs the wide drive; a sine request with narrow drive parks the output.

Top module: `dac_wavegen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dac_code` is zero and `period_sync` is low; the block comes out of reset parked.
- R2: With selector value 00 (park), `dac_code` is zero and `period_sync` stays low, for both widths.
- R3: Selector value 10 gives a rising sawtooth: the level steps through 0, 1, ..., 255 and then wraps to 0. One period is 256 levels.
- R4: Selector value 01 gives a six-level settling sequence 0x00, 0xFF, 0x00, 0x7F, 0x80, 0x7F and then repeats. This covers full-scale rising and falling steps and mid-scale rising and falling steps.
- R5: Selector value 11 with wide drive gives a 256-level sine. For entry k, let h = k mod 128 and a = floor(h*(128-h)*127/4096). The level is 128+a for k<128 and 128-a for k>=128.
- R6: Selector value 11 with narrow drive is taken as park: the code is zero and there is no sync pulse.
- R7: With narrow drive (`wide_sel`=0) the level appears on `dac_code[7:0]` and bits 15:8 are zero. With wide drive the level appears on `dac_code[15:8]` and bits 7:0 are zero.
- R8: Each level is held on `dac_code` for exactly DWELL_CYCLES consecutive clock cycles.
- R9: `period_sync` is high for exactly one cycle, the first cycle of level 0 of every sawtooth, settling or sine period. It is never high at any other time.
- R10: A change of selector or width takes effect only when the running period ends. While parked, a period lasts one dwell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wave_sel | input | 2 | Pattern selector: 00 park, 01 settling, 10 sawtooth, 11 sine |
| wide_sel | input | 1 | 0 drives the low byte, 1 drives the high byte |
| dac_code | output | 16 | Code to the external DAC |
| period_sync | output | 1 | One-cycle pulse at the start of each period |

## Verification
The assertions watch these properties on every cycle:
- the dwell counter stays below its limit;
- the level index stays inside the active period;
- the active configuration changes only at a wrap of the index;
- the code holds still inside a dwell;
- a sine is never active with narrow drive;
- the sync pulse never lasts two cycles.

Only the bench scenarios can show that the level values are right: the sawtooth ramp, the exact settling order and the sine formula. The same holds for the byte placement under both widths. The scenarios also show that a selector change made in the middle of a period is held back until that period has finished.

// File: rtl/dac_wavegen_pkg.sv
package dac_wavegen_pkg;

    localparam int LEVEL_W    = 8;
    localparam int CODE_W     = 2 * LEVEL_W;
    localparam int IDX_W      = 8;
    localparam int SAW_LEN    = 1 << LEVEL_W;
    localparam int SINE_LEN   = 1 << IDX_W;
    localparam int SETTLE_LEN = 6;
    localparam int SINE_QTR   = SINE_LEN / 4;
    localparam int SINE_MID   = 1 << (LEVEL_W - 1);
    localparam int SINE_AMP   = SINE_MID - 1;

    typedef enum logic [1:0] {
        WAVE_PARK   = 2'b00,
        WAVE_SETTLE = 2'b01,
        WAVE_SAW    = 2'b10,
        WAVE_SINE   = 2'b11
    } wave_e;

    typedef struct packed {
        wave_e wave;
        logic  wide;
    } wave_cfg_t;

    function automatic int unsigned period_len(wave_e w);
        case (w)
            WAVE_SETTLE: return SETTLE_LEN;
            WAVE_SAW:    return SAW_LEN;
            WAVE_SINE:   return SINE_LEN;
            default:     return 1;
        endcase
    endfunction

    function automatic logic [LEVEL_W-1:0] settle_level(logic [IDX_W-1:0] step);
        case (step)
            8'd0:    return 8'h00;
            8'd1:    return 8'hFF;
            8'd2:    return 8'h00;
            8'd3:    return 8'h7F;
            8'd4:    return 8'h80;
            default: return 8'h7F;
        endcase
    endfunction

    function automatic logic [LEVEL_W-1:0] quarter_amp(int q);
        return LEVEL_W'((q * (2 * SINE_QTR - q) * SINE_AMP) / (SINE_QTR * SINE_QTR));
    endfunction

    function automatic wave_cfg_t resolve_cfg(logic [1:0] sel, logic wide);
        wave_cfg_t c;
        c.wave = wave_e'(sel);
        c.wide = wide;
        if (c.wave == WAVE_SINE && !wide) c.wave = WAVE_PARK;
        return c;
    endfunction

endpackage

// File: rtl/dac_dwell_timer.sv
module dac_dwell_timer #(
    parameter int DWELL_CYCLES = 2050
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic first
);
    localparam int CNT_W = $clog2(DWELL_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    assign tick  = (cnt == CNT_W'(DWELL_CYCLES - 1));
    assign first = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // dwell counter never passes its limit
    assert_dwell_bound_R8: assert property (@(posedge clk) disable iff (rst)
        32'(cnt) < DWELL_CYCLES);

endmodule

// File: rtl/dac_pattern_seq.sv
module dac_pattern_seq
    import dac_wavegen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       wave_sel,
    input  logic             wide_sel,
    output wave_cfg_t        act,
    output logic [IDX_W-1:0] idx
);
    logic last;

    assign last = (32'(idx) == period_len(act.wave) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act.wave <= WAVE_PARK;
            act.wide <= 1'b0;
            idx      <= '0;
        end else if (tick) begin
            if (last) begin
                act <= resolve_cfg(wave_sel, wide_sel);
                idx <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // index stays within the active period
    assert_idx_in_period_R3: assert property (@(posedge clk) disable iff (rst)
        32'(idx) < period_len(act.wave));

    // configuration is switched only at a period boundary
    assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(act) |-> (idx == '0));

    // sine is never running with narrow drive
    assert_sine_wide_only_R6: assert property (@(posedge clk) disable iff (rst)
        (act.wave == WAVE_SINE) |-> act.wide);

endmodule

// File: rtl/dac_sine_rom.sv
module dac_sine_rom
    import dac_wavegen_pkg::*;
(
    input  logic [IDX_W-1:0]   idx,
    output logic [LEVEL_W-1:0] level
);
    localparam int HALF = 2 * SINE_QTR;

    logic [LEVEL_W-1:0] quarter [0:SINE_QTR];

    generate
        for (genvar i = 0; i <= SINE_QTR; i++) begin : g_quarter
            assign quarter[i] = quarter_amp(i);
        end
    endgenerate

    logic [IDX_W-2:0]   h;
    logic [IDX_W-2:0]   q;
    logic [LEVEL_W-1:0] amp;

    always_comb begin
        h     = idx[IDX_W-2:0];
        q     = h[IDX_W-2] ? (IDX_W-1)'(HALF - int'(h)) : h;
        amp   = quarter[q];
        level = idx[IDX_W-1] ? LEVEL_W'(SINE_MID - int'(amp))
                             : LEVEL_W'(SINE_MID + int'(amp));
    end

endmodule

// File: rtl/dac_wavegen.sv
module dac_wavegen
    import dac_wavegen_pkg::*;
#(
    parameter int DWELL_CYCLES = 2050
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        wave_sel,
    input  logic              wide_sel,
    output logic [CODE_W-1:0] dac_code,
    output logic              period_sync
);
    logic               tick;
    logic               first;
    wave_cfg_t          act;
    logic [IDX_W-1:0]   idx;
    logic [LEVEL_W-1:0] sine_level;
    logic [LEVEL_W-1:0] level;

    dac_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .first (first)
    );

    dac_pattern_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wave_sel (wave_sel),
        .wide_sel (wide_sel),
        .act      (act),
        .idx      (idx)
    );

    dac_sine_rom u_sine (
        .idx   (idx),
        .level (sine_level)
    );

    always_comb begin
        case (act.wave)
            WAVE_SAW:    level = idx[LEVEL_W-1:0];
            WAVE_SETTLE: level = settle_level(idx);
            WAVE_SINE:   level = sine_level;
            default:     level = '0;
        endcase
        dac_code = act.wide ? {level, {LEVEL_W{1'b0}}} : {{LEVEL_W{1'b0}}, level};
    end

    assign period_sync = first && (idx == '0) && (act.wave != WAVE_PARK);

    // code holds still for the whole dwell
    assert_code_held_R8: assert property (@(posedge clk) disable iff (rst)
        !first |-> $stable(dac_code));

    // sync never lasts longer than one cycle
    assert_sync_single_R9: assert property (@(posedge clk) disable iff (rst)
        period_sync |=> !period_sync);

    // narrow drive keeps the upper byte quiet
    assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !act.wide |-> (dac_code[CODE_W-1:LEVEL_W] == '0));

endmodule

// File: tb/dac_wavegen_bench.sv
module dac_wavegen_bench;

    localparam int DW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  wave_sel = 2'b00;
    logic        wide_sel = 1'b0;
    logic [15:0] dac_code;
    logic        period_sync;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dac_wavegen #(.DWELL_CYCLES(DW)) u_dac_wavegen (
        .clk         (clk),
        .rst         (rst),
        .wave_sel    (wave_sel),
        .wide_sel    (wide_sel),
        .dac_code    (dac_code),
        .period_sync (period_sync)
    );

    task automatic check(bit ok, string req, logic [15:0] actual, logic [15:0] expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic logic [7:0] level_of(logic [1:0] m, int k);
        int h;
        int a;
        case (m)
            2'b10: return 8'(k);
            2'b01: begin
                case (k)
                    0: return 8'h00;
                    1: return 8'hFF;
                    2: return 8'h00;
                    3: return 8'h7F;
                    4: return 8'h80;
                    default: return 8'h7F;
                endcase
            end
            2'b11: begin
                h = k % 128;
                a = (h * (128 - h) * 127) / 4096;
                return (k < 128) ? 8'(128 + a) : 8'(128 - a);
            end
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] exp_code(logic [1:0] m, bit w, int k);
        logic [7:0] l;
        l = level_of(m, k);
        return w ? {l, 8'h00} : {8'h00, l};
    endfunction

    task automatic wait_sync(int lim);
        int n = 0;
        while (!period_sync && n < lim) begin
            @(negedge clk);
            n++;
        end
        check(period_sync, "R9 sync start", 16'(period_sync), 16'd1);
    endtask

    task automatic run_period(logic [1:0] m, bit w, int n, string req,
                              int sw_at, logic [1:0] sw_mode, bit sw_wide);
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < DW; c++) begin
                if (k == sw_at && c == 0) begin
                    wave_sel = sw_mode;
                    wide_sel = sw_wide;
                end
                check(dac_code == exp_code(m, w, k), req, dac_code, exp_code(m, w, k));
                check(period_sync == (k == 0 && c == 0), "R9 sync position",
                      16'(period_sync), 16'(k == 0 && c == 0));
                @(negedge clk);
            end
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        wave_sel = 2'b10;
        repeat (4) @(negedge clk);
        check(dac_code == 16'h0, "R1 code in reset", dac_code, 16'h0);
        check(!period_sync, "R1 sync in reset", 16'(period_sync), 16'h0);
        wave_sel = 2'b00;
        rst = 1'b0;
        @(negedge clk);
        check(dac_code == 16'h0, "R1 code after reset", dac_code, 16'h0);
        check(!period_sync, "R1 sync after reset", 16'(period_sync), 16'h0);
    endtask

    task automatic test_park();
        for (int w = 0; w < 2; w++) begin
            wide_sel = w[0];
            for (int i = 0; i < 4 * DW; i++) begin
                check(dac_code == 16'h0, "R2/R7 park code", dac_code, 16'h0);
                check(!period_sync, "R2 park sync", 16'(period_sync), 16'h0);
                @(negedge clk);
            end
        end
    endtask

    task automatic test_sine_narrow();
        wave_sel = 2'b11;
        wide_sel = 1'b0;
        for (int i = 0; i < 10 * DW; i++) begin
            check(dac_code == 16'h0, "R6 narrow sine code", dac_code, 16'h0);
            check(!period_sync, "R6 narrow sine sync", 16'(period_sync), 16'h0);
            @(negedge clk);
        end
    endtask

    task automatic test_saw_narrow();
        wave_sel = 2'b10;
        wide_sel = 1'b0;
        wait_sync(4 * DW);
        run_period(2'b10, 1'b0, 256, "R3/R7/R8 sawtooth", -1, 2'b10, 1'b0);
        check(period_sync, "R9 sync at wrap", 16'(period_sync), 16'h1);
    endtask

    task automatic test_change_mid_period();
        // switch to settling/wide at level 10; sawtooth must finish first
        run_period(2'b10, 1'b0, 256, "R10 hold sawtooth", 10, 2'b01, 1'b1);
        run_period(2'b01, 1'b1, 6, "R4/R7 settling", -1, 2'b01, 1'b1);
        run_period(2'b01, 1'b1, 6, "R4 settling repeat", -1, 2'b01, 1'b1);
    endtask

    task automatic test_sine_wide();
        run_period(2'b01, 1'b1, 6, "R10 hold settling", 0, 2'b11, 1'b1);
        run_period(2'b11, 1'b1, 256, "R5/R7 sine", -1, 2'b11, 1'b1);
        check(period_sync, "R9 sine wrap sync", 16'(period_sync), 16'h1);
    endtask

    initial begin
        test_reset();
        test_park();
        test_sine_narrow();
        test_saw_narrow();
        test_change_mid_period();
        test_sine_wide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule